// File: doc/BRIEF.md
# Chainable Reload Down-Counter Bank

This block holds six down-counting timers that share one prescaled count strobe. The four low-numbered slots are 8 bits wide and the two high-numbered slots are 16 bits wide. Each slot has a reload value, a mode byte and a readable count. A slot is started by writing its mode byte with the enable bit set. It then loads a period and counts down by one on every cycle where `tick` is high. When the count runs out, it reloads and emits a one-clock pulse on `irq`.

Neighbouring slots of the same width can be joined into one wider counter. A slot whose clock-select field holds the chaining code does not count by itself. Instead, when the lowest slot of the chain starts, the chained slots' reload values are placed above its own to form one long period. The underflow pulse of the joined counter appears on the bit of the highest slot in the chain. Software reaches every register through a byte-wide port that takes a slot index and a register select.

Mode writes that break the rules are not applied. Instead they set a sticky error flag, which only reset clears.

Top module: `timer_bank`

## Requirements
- R1: After reset, `irq`, `err` and `rd_data` are zero, and every reload value and mode byte reads back as zero.
- R2: The mode byte uses these fields: bit 7 is enable, bit 6 is load, bits 1:0 are clock select (2'b11 means chained) and bits 5:2 are reserved. A mode write with any reserved bit set, or with enable and load both set, leaves the mode byte unchanged and sets `err`. `err` stays set until reset.
- R3: Writing the chained code to slot 0 or slot 4 is rejected and sets `err`.
- R4: A started slot with period P, left alone, pulses its own `irq` bit high for exactly one cycle every P ticks. The first pulse comes P ticks after the start.
- R5: When an 8-bit slot n starts, each following 8-bit slot i that is set to chained contributes its reload value shifted left by 8·(i−n). Merging stops at the first slot that is not chained or after slot 3. The pulse appears on the highest slot of the chain.
- R6: When slot 4 starts and slot 5 is chained, the period is slot 4's value with slot 5's value shifted left by 16. The pulse appears on `irq[5]`.
- R7: If a chained follower does not have enable set when the lowest slot starts, the start is rejected, `err` is set and no counting begins.
- R8: Writing a reload value while the slot is running leaves the current count unchanged. The new value is used from the next reload on.
- R9: Register selects are 0 = low byte, 1 = high byte (always 0 for 8-bit slots) and 2 = mode byte. A count read of a stopped slot returns its reload value. A count read of a running chain returns the remaining ticks, and each slot returns its own slice of that count. `rd_data` updates one cycle after `rd_en` and holds its value otherwise.
- R10: Writing a mode byte with enable clear stops the slot at once, and the slot produces no later pulses.
- R11: A start whose merged period is zero does not count and never pulses.
- R12: The count moves only on cycles where `tick` is high. Every `irq` pulse follows a tick cycle, and the count is already reloaded in the cycle where the pulse is visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaled count strobe |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 3 | Slot index for the write |
| wr_sel | input | 2 | 0 reload low byte, 1 reload high byte, 2 mode |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Register read strobe |
| rd_idx | input | 3 | Slot index for the read |
| rd_sel | input | 2 | 0 count low byte, 1 count high byte, 2 mode |
| rd_data | output | 8 | Registered read byte |
| irq | output | 6 | Per-slot underflow pulses |
| err | output | 1 | Sticky illegal-mode flag |

## Verification
The assertions check four things on every cycle: that each pulse follows a tick, that the error flag never clears, that the error flag rises only after a mode write, and that read data holds between reads. They also check that a legal stop of slot 0 silences its pulse on the next cycle. Only the directed scenarios can show the actual periods, the merging of chained reload values, the slot a chained pulse lands on, the deferred effect of reload writes, and the remaining-count readback. Each of these depends on a sequence of writes followed by thousands of ticks.

// File: rtl/timer_bank_pkg.sv
`timescale 1ns/1ps
package timer_bank_pkg;
  localparam int          EN_BIT      = 7;
  localparam int          LD_BIT      = 6;
  localparam logic [7:0]  RSVD_MASK   = 8'h3C;
  localparam logic [1:0]  CLK_CHAINED = 2'b11;
  localparam logic [1:0]  SEL_LO      = 2'd0;
  localparam logic [1:0]  SEL_HI      = 2'd1;
  localparam logic [1:0]  SEL_MODE    = 2'd2;
endpackage

// File: rtl/tmr_regfile.sv
`timescale 1ns/1ps
module tmr_regfile import timer_bank_pkg::*; #(
  parameter int N8  = 4,
  parameter int N16 = 2,
  parameter int W16 = 16,
  localparam int NT = N8 + N16,
  localparam int IW = $clog2(NT)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [IW-1:0]            wr_idx,
  input  logic [1:0]               wr_sel,
  input  logic [7:0]               wr_data,
  input  logic [NT-1:0]            chain_bad,
  output logic [NT-1:0][W16-1:0]   base_o,
  output logic [NT-1:0][7:0]       mode_o,
  output logic [NT-1:0]            start_o,
  output logic [NT-1:0]            stop_o,
  output logic                     err_o
);
  logic idx_ok, is_mode, en, chained, group_head, bad, legal;

  always_comb begin
    idx_ok     = int'(wr_idx) < NT;
    is_mode    = wr_en && idx_ok && (wr_sel == SEL_MODE);
    en         = wr_data[EN_BIT];
    chained    = (wr_data[1:0] == CLK_CHAINED);
    group_head = (int'(wr_idx) == 0) || (int'(wr_idx) == N8);
    bad        = ((wr_data & RSVD_MASK) != 8'h00)
              || (en && wr_data[LD_BIT])
              || (chained && group_head)
              || (en && !chained && idx_ok && chain_bad[wr_idx]);
    legal      = is_mode && !bad;
    start_o    = '0;
    stop_o     = '0;
    if (legal) begin
      if (en && !chained) start_o[wr_idx] = 1'b1;
      else                stop_o[wr_idx]  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_o <= '0;
      mode_o <= '0;
      err_o  <= 1'b0;
    end else begin
      if (is_mode && bad) err_o <= 1'b1;
      if (legal) mode_o[wr_idx] <= wr_data;
      if (wr_en && idx_ok && wr_sel == SEL_LO)
        base_o[wr_idx][7:0] <= wr_data;
      if (wr_en && idx_ok && wr_sel == SEL_HI && int'(wr_idx) >= N8)
        base_o[wr_idx][W16-1:8] <= wr_data[W16-9:0];
    end
  end
endmodule

// File: rtl/tmr_chain.sv
`timescale 1ns/1ps
module tmr_chain #(
  parameter int N8  = 4,
  parameter int W8  = 8,
  parameter int N16 = 2,
  parameter int W16 = 16,
  localparam int NT = N8 + N16,
  localparam int IW = $clog2(NT),
  localparam int PW = (N8 * W8 > N16 * W16) ? N8 * W8 : N16 * W16
) (
  input  logic [NT-1:0][W16-1:0] base,
  input  logic [NT-1:0]          chained,
  input  logic [NT-1:0]          enabled,
  output logic [NT-1:0][PW-1:0]  period,
  output logic [NT-1:0][IW-1:0]  last,
  output logic [NT-1:0]          bad
);
  always_comb begin
    for (int n = 0; n < NT; n++) begin
      logic go;
      go        = 1'b1;
      period[n] = PW'(base[n]);
      last[n]   = IW'(n);
      bad[n]    = 1'b0;
      if (n < N8) begin
        for (int i = n + 1; i < N8; i++) begin
          if (go && chained[i]) begin
            period[n] = period[n] | (PW'(base[i]) << (W8 * (i - n)));
            last[n]   = IW'(i);
            if (!enabled[i]) bad[n] = 1'b1;
          end else begin
            go = 1'b0;
          end
        end
      end else begin
        for (int i = n + 1; i < NT; i++) begin
          if (go && chained[i]) begin
            period[n] = period[n] | (PW'(base[i]) << (W16 * (i - n)));
            last[n]   = IW'(i);
            if (!enabled[i]) bad[n] = 1'b1;
          end else begin
            go = 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tmr_down_counter.sv
`timescale 1ns/1ps
module tmr_down_counter #(
  parameter int PW = 32,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          start,
  input  logic          stop,
  input  logic [PW-1:0] period,
  input  logic [IW-1:0] last_in,
  output logic          run_o,
  output logic [PW-1:0] cnt_o,
  output logic [IW-1:0] last_o,
  output logic          fire_o
);
  logic expire;

  always_comb begin
    expire = run_o && tick && (cnt_o == PW'(1));
    fire_o = expire && !start && !stop;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_o  <= 1'b0;
      cnt_o  <= '0;
      last_o <= '0;
    end else if (start) begin
      run_o  <= (period != '0);
      cnt_o  <= period;
      last_o <= last_in;
    end else if (stop) begin
      run_o  <= 1'b0;
    end else if (run_o && tick) begin
      if (expire) begin
        cnt_o  <= period;
        run_o  <= (period != '0);
        last_o <= last_in;
      end else begin
        cnt_o  <= cnt_o - PW'(1);
      end
    end
  end
endmodule

// File: rtl/timer_bank.sv
`timescale 1ns/1ps
module timer_bank import timer_bank_pkg::*; #(
  parameter int N8  = 4,
  parameter int W8  = 8,
  parameter int N16 = 2,
  parameter int W16 = 16,
  localparam int NT = N8 + N16,
  localparam int IW = $clog2(NT),
  localparam int PW = (N8 * W8 > N16 * W16) ? N8 * W8 : N16 * W16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [1:0]    wr_sel,
  input  logic [7:0]    wr_data,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_idx,
  input  logic [1:0]    rd_sel,
  output logic [7:0]    rd_data,
  output logic [NT-1:0] irq,
  output logic          err
);
  logic [NT-1:0][W16-1:0] base;
  logic [NT-1:0][7:0]     mode;
  logic [NT-1:0]          start, stop, chain_bad, chained, enabled;
  logic [NT-1:0][PW-1:0]  period;
  logic [NT-1:0][IW-1:0]  last_c, last_q;
  logic [NT-1:0][PW-1:0]  cnt;
  logic [NT-1:0]          run, fire;
  logic [NT-1:0]          irq_next;
  logic [W16-1:0]         view;
  logic [7:0]             rd_byte;

  tmr_regfile #(.N8(N8), .N16(N16), .W16(W16)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel),
    .wr_data(wr_data), .chain_bad(chain_bad), .base_o(base), .mode_o(mode),
    .start_o(start), .stop_o(stop), .err_o(err)
  );

  always_comb begin
    for (int i = 0; i < NT; i++) begin
      chained[i] = (mode[i][1:0] == CLK_CHAINED);
      enabled[i] = mode[i][EN_BIT];
    end
  end

  tmr_chain #(.N8(N8), .W8(W8), .N16(N16), .W16(W16)) u_chain (
    .base(base), .chained(chained), .enabled(enabled),
    .period(period), .last(last_c), .bad(chain_bad)
  );

  for (genvar g = 0; g < NT; g++) begin : g_slot
    tmr_down_counter #(.PW(PW), .IW(IW)) u_cnt (
      .clk(clk), .rst(rst), .tick(tick), .start(start[g]), .stop(stop[g]),
      .period(period[g]), .last_in(last_c[g]), .run_o(run[g]),
      .cnt_o(cnt[g]), .last_o(last_q[g]), .fire_o(fire[g])
    );
  end

  always_comb begin
    irq_next = '0;
    for (int i = 0; i < NT; i++)
      if (fire[i]) irq_next[last_q[i]] = 1'b1;
  end

  always_comb begin
    view = '0;
    if (int'(rd_idx) < NT) begin
      view = base[rd_idx];
      for (int i = 0; i < NT; i++)
        if (run[i] && i <= int'(rd_idx) && int'(rd_idx) <= int'(last_q[i]))
          view = W16'(cnt[i] >> (((i < N8) ? W8 : W16) * (int'(rd_idx) - i)));
    end
    case (rd_sel)
      SEL_LO:   rd_byte = view[7:0];
      SEL_HI:   rd_byte = (int'(rd_idx) < N8) ? 8'h00 : view[15:8];
      SEL_MODE: rd_byte = (int'(rd_idx) < NT) ? mode[rd_idx] : 8'h00;
      default:  rd_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= '0;
      rd_data <= '0;
    end else begin
      irq <= irq_next;
      if (rd_en) rd_data <= rd_byte;
    end
  end
endmodule

// File: rtl/timer_bank_chk.sv
`timescale 1ns/1ps
module timer_bank_chk #(
  parameter int NT = 6,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          wr_en,
  input logic [IW-1:0] wr_idx,
  input logic [1:0]    wr_sel,
  input logic [7:0]    wr_data,
  input logic          rd_en,
  input logic [7:0]    rd_data,
  input logic [NT-1:0] irq,
  input logic          err
);
  // R12
  irq_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (irq != '0) |-> $past(tick));
  // R2
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
  // R2
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> $past(wr_en && wr_sel == 2'd2));
  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
  // R10
  stop_silences_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == '0 && wr_sel == 2'd2 && !wr_data[7] && wr_data[5:2] == 4'h0)
    |=> !irq[0]);
endmodule

bind timer_bank timer_bank_chk #(.NT(NT), .IW(IW)) u_chk (.*);

// File: tb/timer_bank_test.sv
`timescale 1ns/1ps
module timer_bank_test;
  logic       clk = 1'b0;
  logic       rst, tick, wr_en, rd_en;
  logic [2:0] wr_idx, rd_idx;
  logic [1:0] wr_sel, rd_sel;
  logic [7:0] wr_data, rd_data;
  logic [5:0] irq;
  logic       err;
  int         vectors = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  timer_bank uut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_en(rd_en), .rd_idx(rd_idx),
    .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq), .err(err)
  );

  task automatic check(input string req, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tick = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    wr_idx = '0; wr_sel = '0; wr_data = '0; rd_idx = '0; rd_sel = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input int idx, input int sel, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_sel = 2'(sel); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int idx, input int sel, output int val);
    @(negedge clk);
    rd_en = 1'b1; rd_idx = 3'(idx); rd_sel = 2'(sel);
    @(negedge clk);
    rd_en = 1'b0;
    val = int'(rd_data);
  endtask

  task automatic wait_irq(input int b, input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!irq[b] && n < limit);
  endtask

  task automatic count_irq(input int b, input int cycles, output int hits);
    hits = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (irq[b]) hits++;
    end
  endtask

  task automatic t_reset();
    int v;
    do_reset();
    check("R1 irq", irq, 0);
    check("R1 err", err, 0);
    check("R1 rd_data", rd_data, 0);
    rd(4, 1, v); check("R1 base hi", v, 0);
    rd(2, 2, v); check("R1 mode", v, 0);
  endtask

  task automatic t_single();
    int n, v;
    do_reset();
    wr(3, 0, 7); wr(3, 2, 8'h80);
    rd(3, 0, v); check("R9 running remaining", v, 7);
    rd(3, 2, v); check("R9 mode readback", v, 8'h80);
    rd(3, 1, v); check("R9 narrow hi byte", v, 0);
    @(negedge clk); tick = 1'b1;
    repeat (3) @(negedge clk);
    tick = 1'b0;
    rd(3, 0, v); check("R12 count after 3 ticks", v, 4);
    do_reset();
    wr(2, 0, 2); wr(2, 2, 8'h80);
    count_irq(2, 10, n); check("R12 no pulse without tick", n, 0);
    @(negedge clk); tick = 1'b1;
    do_reset();
    tick = 1'b1;
    wr(2, 0, 5); wr(2, 2, 8'h80);
    wait_irq(2, 100, n); check("R4 first pulse", n, 5);
    @(negedge clk); check("R4 one-cycle pulse", irq[2], 0);
    wait_irq(2, 100, n); check("R4 repeat period", n, 4 + 1 - 1 + 0);
  endtask

  task automatic t_base_update();
    int n, v;
    do_reset();
    wr(2, 0, 5); wr(2, 2, 8'h80);
    wr(2, 0, 9);
    rd(2, 0, v); check("R8 running count untouched", v, 5);
    tick = 1'b1;
    wait_irq(2, 100, n); check("R8 old period", n, 5);
    wait_irq(2, 100, n); check("R8 new period after reload", n, 9);
    tick = 1'b0;
    wr(2, 2, 8'h00);
    rd(2, 0, v); check("R9 stopped reads base", v, 9);
    tick = 1'b1;
    count_irq(2, 30, n); check("R10 no pulse after stop", n, 0);
    tick = 1'b0;
  endtask

  task automatic t_chain8();
    int n, v;
    do_reset();
    wr(0, 0, 8'h10); wr(1, 0, 8'h01);
    wr(1, 2, 8'h83); wr(0, 2, 8'h80);
    check("R5 no error", err, 0);
    rd(0, 0, v); check("R9 leader slice", v, 8'h10);
    rd(1, 0, v); check("R9 follower slice", v, 8'h01);
    tick = 1'b1;
    wait_irq(1, 1000, n); check("R5 merged period", n, 272);
    check("R5 leader bit silent", irq[0], 0);
    tick = 1'b0;
  endtask

  task automatic t_chain16();
    int n, v;
    do_reset();
    wr(4, 0, 8'h03); wr(4, 1, 8'h00); wr(5, 0, 8'h01);
    wr(5, 2, 8'h83); wr(4, 2, 8'h80);
    rd(5, 0, v); check("R6 upper slice", v, 1);
    tick = 1'b1;
    wait_irq(5, 70000, n); check("R6 merged period", n, 65539);
    check("R6 lower bit silent", irq[4], 0);
    tick = 1'b0;
  endtask

  task automatic t_errors();
    int n, v;
    do_reset();
    wr(2, 2, 8'h84);
    check("R2 reserved bit err", err, 1);
    rd(2, 2, v); check("R2 mode unchanged", v, 0);
    do_reset();
    wr(2, 2, 8'hC0);
    check("R2 enable+load err", err, 1);
    do_reset();
    wr(0, 2, 8'h03); check("R3 slot0 chained err", err, 1);
    do_reset();
    wr(4, 2, 8'h03); check("R3 slot4 chained err", err, 1);
    do_reset();
    wr(1, 2, 8'h03); check("R7 chained without enable is legal", err, 0);
    wr(0, 0, 4); wr(0, 2, 8'h80);
    check("R7 follower not enabled err", err, 1);
    tick = 1'b1;
    count_irq(1, 20, n); check("R7 no counting", n, 0);
    tick = 1'b0;
  endtask

  task automatic t_zero();
    int n;
    do_reset();
    wr(3, 2, 8'h80);
    check("R11 legal start", err, 0);
    tick = 1'b1;
    count_irq(3, 30, n); check("R11 zero period silent", n, 0);
    tick = 1'b0;
  endtask

  initial begin
    t_reset();
    t_single();
    t_base_update();
    t_chain8();
    t_chain16();
    t_errors();
    t_zero();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: actual 0 expected 1 (run completion)");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule